// File: doc/BRIEF.md
# Bus Parity Generator and Checker

This block produces and verifies even parity for a multiplexed 32-bit address/data bus that travels with a 4-bit command/byte-enable bus. When the surrounding bus logic drives the lines, the block registers the parity of the 36 driven bits. It presents that bit, together with its active-low output enable, one clock later. When the block receives, it compares the parity bit arriving in a cycle with the parity of the lines captured in the cycle before.

Mismatches are sorted by the kind of phase they cover. A data phase that actually moved data raises a one-clock pulse on the parity-error line, two clocks after that phase. An address phase, or a data phase of a broadcast special cycle, raises the pulse on the system-error line instead. Every report also sets a sticky status bit. The bit holds until software writes a 1 to clear it. The bus sequencer tells the block which cycle carries an address, feeds it the two ready strobes, and says whether the block itself is driving the lines.

Top module: `pci_parity_unit`

## Requirements
- R1: In the cycle after any cycle, `par_out` equals the XOR of the 36 bits `ad_out` and `cbe_out` sampled in that earlier cycle. The count of ones over those bits plus `par_out` is therefore even.
- R2: `par_oe_n` equals the value `ad_oe_n` had one clock earlier.
- R3: A cycle with `addr_phase`=1 and `ad_oe_n`=1 is a checked address phase. If `par_in` in the following cycle differs from the XOR of that phase's `ad_in` and `cbe_in`, then `serr_out_n` and `serr_oe_n` are both 0 for exactly one clock, one cycle after that parity cycle.
- R4: A cycle with `addr_phase`=0, `ad_oe_n`=1, `irdy_n`=0 and `trdy_n`=0 is a checked data phase, provided the latched command is not the special cycle. A parity mismatch found in the next cycle drives `perr_out_n` and `perr_oe_n` to 0 for one clock, two clocks after the data phase.
- R5: The command is taken from `cbe_in` on every address phase and held until the next one. While the held command is 4'b0001 (special cycle), data phases need only `irdy_n`=0. Their parity mismatches are reported on the system-error outputs and never on the parity-error outputs.
- R6: A phase is never checked if it has `ad_oe_n`=0, or if it has `irdy_n`=1, or if it has `trdy_n`=1 while the held command is not special. Such a phase produces no error pulse, whatever `par_in` follows it.
- R7: `sts[0]` (data parity error detected) and `sts[1]` (system error signalled) become 1 in the same cycle as their error pulse appears. Each stays 1 afterwards.
- R8: `sts_clr[k]`=1 in a cycle clears `sts[k]` at the next clock edge. If a new report for bit k arrives in that same cycle, the bit stays set.
- R9: While `rst_n` is low, and for two clock edges after it rises, `par_out`=0 and `sts`=0. All four error outputs and `par_oe_n` are held at 1 during that time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ad_out | input | 32 | Address/data value the bus logic drives |
| cbe_out | input | 4 | Command/byte-enable value the bus logic drives |
| ad_oe_n | input | 1 | Active-low: the block's side is driving AD and C/BE this cycle |
| ad_in | input | 32 | Address/data lines as sampled from the bus |
| cbe_in | input | 4 | Command/byte-enable lines as sampled from the bus |
| par_in | input | 1 | Parity line as sampled from the bus |
| addr_phase | input | 1 | This cycle carries an address and command |
| irdy_n | input | 1 | Initiator ready, active low |
| trdy_n | input | 1 | Target ready, active low |
| sts_clr | input | 2 | Write-one-to-clear strobes for the status bits |
| par_out | output | 1 | Generated parity bit |
| par_oe_n | output | 1 | Active-low enable for the parity bit |
| perr_out_n | output | 1 | Data parity error, active low |
| perr_oe_n | output | 1 | Active-low enable for the data parity error line |
| serr_out_n | output | 1 | System error, active low |
| serr_oe_n | output | 1 | Active-low enable for the system error line |
| sts | output | 2 | Sticky status: bit 0 data parity error, bit 1 system error |

## Verification
Two functions can fall in the same cycle: a new error report setting a status bit, and a software clear of that same bit. The bench provokes this with a directed case. It corrupts the parity after a data phase and raises `sts_clr[0]` in the cycle where the mismatch is seen, then judges that `sts[0]` is still 1 afterwards. A second cycle of clear alone must then read 0. A long pseudo-random sweep mixes address phases, special and ordinary commands, ready combinations, drive direction and clears. It is judged every cycle against a phase-history model of the requirements.

// File: rtl/pci_par_pkg.sv
package pci_par_pkg;
  localparam logic [3:0] CMD_SPECIAL = 4'b0001;
  localparam int STS_DATA = 0;
  localparam int STS_SYS  = 1;
  localparam int STS_W    = 2;
endpackage

// File: rtl/par_gen.sv
module par_gen #(
  parameter int AD_W  = 32,
  parameter int CBE_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AD_W-1:0]  ad_out,
  input  logic [CBE_W-1:0] cbe_out,
  input  logic             ad_oe_n,
  output logic             par_out,
  output logic             par_oe_n
);
  localparam int PW = AD_W + CBE_W;

  logic [PW-1:0] cover_bits;
  logic          par_d, par_q;
  logic          oe_d, oe_q;

  always_comb begin
    cover_bits = {ad_out, cbe_out};
    par_d      = ^cover_bits;
    oe_d       = ad_oe_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      par_q <= 1'b0;
      oe_q  <= 1'b1;
    end else begin
      par_q <= par_d;
      oe_q  <= oe_d;
    end
  end

  assign par_out  = par_q;
  assign par_oe_n = oe_q;

  assert_oe_follow_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !ad_oe_n |=> !par_oe_n);
  assert_oe_follow_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ad_oe_n |=> par_oe_n);
endmodule

// File: rtl/par_chk.sv
module par_chk
  import pci_par_pkg::*;
#(
  parameter int AD_W  = 32,
  parameter int CBE_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AD_W-1:0]  ad_in,
  input  logic [CBE_W-1:0] cbe_in,
  input  logic             par_in,
  input  logic             ad_oe_n,
  input  logic             addr_phase,
  input  logic             irdy_n,
  input  logic             trdy_n,
  output logic             perr_set,
  output logic             serr_set,
  output logic             perr_pulse,
  output logic             serr_pulse
);
  localparam int PW = AD_W + CBE_W;

  logic [PW-1:0]    seen_bits;
  logic             rx_par_d, rx_par_q;
  logic [CBE_W-1:0] cmd_d, cmd_q;
  logic             cmd_en;
  logic             cmd_special;
  logic             addr_chk_d, addr_chk_q;
  logic             data_chk_d, data_chk_q;
  logic             spec_d, spec_q;
  logic             mismatch;
  logic             perr_d, perr_q;
  logic             serr_d, serr_q;

  // next-state: capture phase and lines this cycle
  always_comb begin
    seen_bits   = {ad_in, cbe_in};
    rx_par_d    = ^seen_bits;
    cmd_en      = addr_phase;
    cmd_d       = cbe_in;
    cmd_special = (cmd_q == CBE_W'(CMD_SPECIAL));
    addr_chk_d  = addr_phase & ad_oe_n;
    data_chk_d  = ~addr_phase & ad_oe_n & ~irdy_n & (~trdy_n | cmd_special);
    spec_d      = cmd_special;
  end

  // compare previous cycle's lines with the parity arriving now
  always_comb begin
    mismatch = rx_par_q ^ par_in;
    perr_d   = mismatch & data_chk_q & ~spec_q;
    serr_d   = mismatch & (addr_chk_q | (data_chk_q & spec_q));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_par_q   <= 1'b0;
      addr_chk_q <= 1'b0;
      data_chk_q <= 1'b0;
      spec_q     <= 1'b0;
      perr_q     <= 1'b0;
      serr_q     <= 1'b0;
    end else begin
      rx_par_q   <= rx_par_d;
      addr_chk_q <= addr_chk_d;
      data_chk_q <= data_chk_d;
      spec_q     <= spec_d;
      perr_q     <= perr_d;
      serr_q     <= serr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q <= '0;
    end else if (cmd_en) begin
      cmd_q <= cmd_d;
    end
  end

  assign perr_set   = perr_d;
  assign serr_set   = serr_d;
  assign perr_pulse = perr_q;
  assign serr_pulse = serr_q;

  assert_perr_after_data_R4: assert property (@(posedge clk) disable iff (!rst_n)
    perr_q |-> $past(data_chk_q & ~spec_q));
  assert_serr_source_R3: assert property (@(posedge clk) disable iff (!rst_n)
    serr_q |-> $past(addr_chk_q | (data_chk_q & spec_q)));
  assert_split_reports_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({perr_q, serr_q}));
  assert_driven_unchecked_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !ad_oe_n |=> !(data_chk_q | addr_chk_q));
endmodule

// File: rtl/par_sticky.sv
module par_sticky #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] sts_o
);
  for (genvar k = 0; k < N; k++) begin : g_bit
    logic bit_d, bit_q, bit_en;

    always_comb begin
      bit_en = set_i[k] | clr_i[k];
      bit_d  = set_i[k];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        bit_q <= 1'b0;
      end else if (bit_en) begin
        bit_q <= bit_d;
      end
    end

    assign sts_o[k] = bit_q;

    assert_set_lands_R7: assert property (@(posedge clk) disable iff (!rst_n)
      set_i[k] |=> sts_o[k]);
    assert_hold_until_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (sts_o[k] && !clr_i[k]) |=> sts_o[k]);
    assert_clear_works_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i[k] && !set_i[k]) |=> !sts_o[k]);
  end
endmodule

// File: rtl/pci_parity_unit.sv
module pci_parity_unit
  import pci_par_pkg::*;
#(
  parameter int AD_W  = 32,
  parameter int CBE_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AD_W-1:0]  ad_out,
  input  logic [CBE_W-1:0] cbe_out,
  input  logic             ad_oe_n,
  input  logic [AD_W-1:0]  ad_in,
  input  logic [CBE_W-1:0] cbe_in,
  input  logic             par_in,
  input  logic             addr_phase,
  input  logic             irdy_n,
  input  logic             trdy_n,
  input  logic [STS_W-1:0] sts_clr,
  output logic             par_out,
  output logic             par_oe_n,
  output logic             perr_out_n,
  output logic             perr_oe_n,
  output logic             serr_out_n,
  output logic             serr_oe_n,
  output logic [STS_W-1:0] sts
);
  logic rst_meta, rst_s;
  logic perr_set, serr_set, perr_pulse, serr_pulse;
  logic [STS_W-1:0] sts_set;

  // reset asserts at once, releases after two edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_s    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_s    <= rst_meta;
    end
  end

  par_gen #(.AD_W(AD_W), .CBE_W(CBE_W)) u_gen (
    .clk      (clk),
    .rst_n    (rst_s),
    .ad_out   (ad_out),
    .cbe_out  (cbe_out),
    .ad_oe_n  (ad_oe_n),
    .par_out  (par_out),
    .par_oe_n (par_oe_n)
  );

  par_chk #(.AD_W(AD_W), .CBE_W(CBE_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_s),
    .ad_in      (ad_in),
    .cbe_in     (cbe_in),
    .par_in     (par_in),
    .ad_oe_n    (ad_oe_n),
    .addr_phase (addr_phase),
    .irdy_n     (irdy_n),
    .trdy_n     (trdy_n),
    .perr_set   (perr_set),
    .serr_set   (serr_set),
    .perr_pulse (perr_pulse),
    .serr_pulse (serr_pulse)
  );

  always_comb begin
    sts_set           = '0;
    sts_set[STS_DATA] = perr_set;
    sts_set[STS_SYS]  = serr_set;
  end

  par_sticky #(.N(STS_W)) u_sts (
    .clk   (clk),
    .rst_n (rst_s),
    .set_i (sts_set),
    .clr_i (sts_clr),
    .sts_o (sts)
  );

  assign perr_out_n = ~perr_pulse;
  assign perr_oe_n  = ~perr_pulse;
  assign serr_out_n = ~serr_pulse;
  assign serr_oe_n  = ~serr_pulse;

  assert_reset_quiet_R9: assert property (@(posedge clk)
    !rst_s |=> (!rst_s -> (par_oe_n && perr_out_n && serr_out_n && sts == '0)));
  assert_pulse_marks_status_R7: assert property (@(posedge clk) disable iff (!rst_s)
    !perr_out_n |-> sts[STS_DATA]);
endmodule

// File: tb/pci_parity_unit_test.sv
module pci_parity_unit_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] ad_out, ad_in;
  logic [3:0]  cbe_out, cbe_in;
  logic        ad_oe_n, par_in, addr_phase, irdy_n, trdy_n;
  logic [1:0]  sts_clr;
  logic        par_out, par_oe_n, perr_out_n, perr_oe_n, serr_out_n, serr_oe_n;
  logic [1:0]  sts;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  // bench model of the history of phases
  bit         m_run = 0;
  logic       e_par, e_paroe, e_perr, e_serr;
  logic [1:0] e_sts;
  logic       h_par, h_addr, h_data, h_spec;
  logic [3:0] h_cmd;
  logic [31:0] seed = 32'h1ACE_B00C;

  always #2 clk = ~clk;

  pci_parity_unit uut (
    .clk(clk), .rst_n(rst_n), .ad_out(ad_out), .cbe_out(cbe_out), .ad_oe_n(ad_oe_n),
    .ad_in(ad_in), .cbe_in(cbe_in), .par_in(par_in), .addr_phase(addr_phase),
    .irdy_n(irdy_n), .trdy_n(trdy_n), .sts_clr(sts_clr), .par_out(par_out),
    .par_oe_n(par_oe_n), .perr_out_n(perr_out_n), .perr_oe_n(perr_oe_n),
    .serr_out_n(serr_out_n), .serr_oe_n(serr_oe_n), .sts(sts)
  );

  function automatic logic [31:0] nxt(input logic [31:0] s);
    logic [31:0] x = s;
    x = x ^ (x << 13);
    x = x ^ (x >> 17);
    x = x ^ (x << 5);
    return x;
  endfunction

  function automatic logic odd36(input logic [31:0] d, input logic [3:0] c);
    return logic'(($countones(d) + $countones(c)) % 2);
  endfunction

  task automatic chk(input string tag, input logic [1:0] got, input logic [1:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%b exp=%b t=%0t", tag, got, exp, $time);
    end
  endtask

  task automatic model_update();
    logic mis, pn, sn, spec_now, dchk;
    mis = h_par ^ par_in;
    pn  = mis & h_data & ~h_spec;
    sn  = mis & (h_addr | (h_data & h_spec));
    e_sts[0] = pn | (e_sts[0] & ~sts_clr[0]);
    e_sts[1] = sn | (e_sts[1] & ~sts_clr[1]);
    e_perr = pn;
    e_serr = sn;
    e_par   = odd36(ad_out, cbe_out);
    e_paroe = ad_oe_n;
    spec_now = (h_cmd == 4'b0001);
    dchk = !addr_phase && ad_oe_n && !irdy_n && (!trdy_n || spec_now);
    h_par  = odd36(ad_in, cbe_in);
    h_addr = addr_phase && ad_oe_n;
    h_data = dchk;
    h_spec = spec_now;
    if (addr_phase) h_cmd = cbe_in;
  endtask

  task automatic compare_all();
    chk("R1 par_out", {1'b0, par_out}, {1'b0, e_par});
    chk("R2 par_oe_n", {1'b0, par_oe_n}, {1'b0, e_paroe});
    chk("R4/R6 perr_out_n,perr_oe_n", {perr_out_n, perr_oe_n}, {~e_perr, ~e_perr});
    chk("R3/R5 serr_out_n,serr_oe_n", {serr_out_n, serr_oe_n}, {~e_serr, ~e_serr});
    chk("R7/R8 sts", sts, e_sts);
  endtask

  // one bus cycle: check what the last edge produced, then drive the next cycle
  task automatic step(input logic a, input logic [3:0] c, input logic [31:0] d,
                      input logic ir, input logic tr, input logic oe,
                      input logic corrupt, input logic [1:0] clr,
                      input logic [31:0] dout, input logic [3:0] cout);
    @(negedge clk);
    if (m_run) begin
      model_update();
      compare_all();
    end
    par_in     = odd36(ad_in, cbe_in) ^ corrupt;
    ad_in      = d;
    cbe_in     = c;
    addr_phase = a;
    irdy_n     = ir;
    trdy_n     = tr;
    ad_oe_n    = oe;
    sts_clr    = clr;
    ad_out     = dout;
    cbe_out    = cout;
  endtask

  task automatic idle(input logic corrupt, input logic [1:0] clr);
    step(1'b0, 4'hF, 32'h0, 1'b1, 1'b1, 1'b1, corrupt, clr, 32'h0, 4'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    ad_out = '0; cbe_out = '0; ad_oe_n = 1'b1; ad_in = '0; cbe_in = 4'hF;
    par_in = 1'b0; addr_phase = 1'b0; irdy_n = 1'b1; trdy_n = 1'b1; sts_clr = '0;
    repeat (3) @(negedge clk);
    // R9: reset state
    chk("R9 reset par_out,par_oe_n", {par_out, par_oe_n}, 2'b01);
    chk("R9 reset perr pair", {perr_out_n, perr_oe_n}, 2'b11);
    chk("R9 reset serr pair", {serr_out_n, serr_oe_n}, 2'b11);
    chk("R9 reset sts", sts, 2'b00);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9 held after release", {par_oe_n, perr_out_n}, 2'b11);
    repeat (3) @(negedge clk);
    e_par = 0; e_paroe = 1; e_perr = 0; e_serr = 0; e_sts = 0;
    h_par = 0; h_addr = 0; h_data = 0; h_spec = 0; h_cmd = 0;
    m_run = 1;

    // R1/R2: drive sweep over every command value and walking data bits
    for (int c = 0; c < 16; c++)
      for (int b = 0; b < 33; b++)
        step(1'b0, 4'hF, 32'h0, 1'b1, 1'b1, logic'(b % 3 == 0), 1'b0, 2'b00,
             (b == 32) ? 32'hFFFF_FFFF : (32'h1 << b) ^ (32'h0 + c * 32'h0101), 4'(c));

    // R4: ordinary write, one good and one corrupted data phase
    step(1'b1, 4'b0111, 32'h0000_1000, 1'b1, 1'b1, 1'b1, 1'b0, 2'b00, 32'h0, 4'h0);
    step(1'b0, 4'b0000, 32'hDEAD_BEEF, 1'b0, 1'b0, 1'b1, 1'b0, 2'b00, 32'h0, 4'h0);
    step(1'b0, 4'b0011, 32'h1234_5678, 1'b0, 1'b0, 1'b1, 1'b0, 2'b00, 32'h0, 4'h0);
    idle(1'b1, 2'b00);
    idle(1'b0, 2'b00);
    idle(1'b0, 2'b00);
    // R8: clear sts[0] in same cycle as a new data error is found -> stays set
    step(1'b0, 4'b0000, 32'h0F0F_0F0F, 1'b0, 1'b0, 1'b1, 1'b0, 2'b00, 32'h0, 4'h0);
    idle(1'b1, 2'b01);
    idle(1'b0, 2'b00);
    idle(1'b0, 2'b01);
    idle(1'b0, 2'b00);
    // R3: corrupted address phase
    step(1'b1, 4'b0110, 32'h8000_0004, 1'b1, 1'b1, 1'b1, 1'b0, 2'b00, 32'h0, 4'h0);
    idle(1'b1, 2'b00);
    idle(1'b0, 2'b00);
    // R5: special cycle, data with initiator ready only, corrupted
    step(1'b1, 4'b0001, 32'h0, 1'b1, 1'b1, 1'b1, 1'b0, 2'b10, 32'h0, 4'h0);
    step(1'b0, 4'b0000, 32'hCAFE_0001, 1'b0, 1'b1, 1'b1, 1'b0, 2'b00, 32'h0, 4'h0);
    idle(1'b1, 2'b00);
    idle(1'b0, 2'b00);
    // R6: target not ready, and block driving: corrupted but ignored
    step(1'b1, 4'b0111, 32'h0000_2000, 1'b1, 1'b1, 1'b1, 1'b0, 2'b11, 32'h0, 4'h0);
    step(1'b0, 4'b0000, 32'h5555_AAAA, 1'b0, 1'b1, 1'b1, 1'b0, 2'b00, 32'h0, 4'h0);
    idle(1'b1, 2'b00);
    step(1'b0, 4'b0000, 32'h3333_CCCC, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 32'h3333_CCCC, 4'h0);
    idle(1'b1, 2'b00);
    idle(1'b0, 2'b00);
    idle(1'b0, 2'b00);

    // near-exhaustive pseudo-random sweep against the model
    for (int i = 0; i < 6000; i++) begin
      logic a;
      logic [3:0] c;
      logic [31:0] r1, r2;
      seed = nxt(seed); r1 = seed;
      seed = nxt(seed); r2 = seed;
      a = (r1[2:0] == 3'd0);
      c = r1[7:4];
      if (a && r1[9:8] == 2'd0) c = 4'b0001;
      if (a && r1[9:8] == 2'd1) c = 4'b0111;
      step(a, c, r2, r1[10], r1[11], (r1[13:12] == 2'd0) ? 1'b0 : 1'b1,
           (r1[15:14] == 2'd0), (r1[18:16] == 3'd0) ? r1[20:19] : 2'b00,
           r2 ^ r1, r1[27:24]);
    end
    repeat (3) idle(1'b0, 2'b00);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule